// File: doc/BRIEF.md
# Conditional Branch Resolver

This unit settles PC-relative branches for a 16-bit instruction stream. When a valid instruction word arrives together with the current status flags and the address of that instruction, the resolver checks whether the word belongs to the branch format. If it does, the resolver picks one of sixteen condition codes and tests the negative, overflow, carry and zero flags against it. It then reports, one clock later, whether the branch is taken and where it goes.

The destination is the address of the following instruction plus a signed 9-bit displacement. The displacement counts 16-bit characters, so it is doubled before it is added. One condition code is a relative subroutine call. For that code the branch is always taken, and the resolver also asks for the link register (r15) to be written with the return address. Fetch redirection, pipeline flushing and the register file itself sit outside this unit. The resolver never modifies flags.

Top module: `branch_resolver`

## Requirements
- R1: While `rstN` is low, and on the first clock after it, `isBranch`, `brTaken`, `linkWe` and `linkIdx` are 0, and `brTarget` and `linkData` are all zeros.
- R2: A word is a branch when `inValid` is 1 and `instrWord[15:13]` equals 3'b101. `isBranch` is 1 in the cycle after such a word is sampled, and 0 after any other sample.
- R3: For the signed condition codes in `instrWord[11:8]`, `brTaken` follows the flags sampled with the word: 0 taken when N xor V, 1 taken when not (N xor V), 2 taken when (N xor V) or Z, 3 taken when neither (N xor V) nor Z.
- R4: For the unsigned codes, C is treated as a borrow: 4 taken when C, 5 taken when not C, 6 taken when C or Z, 7 taken when neither C nor Z.
- R5: Code 8 is taken when Z, 9 when not Z, A when N, and B when not N.
- R6: Codes C and D are never taken. Code E is always taken and requests no link write.
- R7: Code F is always taken. In the cycle after it is sampled, `linkWe` is 1, `linkIdx` is 15 and `linkData` equals the sampled `curPc` plus 2. After every other sample, `linkWe` and `linkIdx` are 0.
- R8: After a branch word is sampled, `brTarget` equals `curPc + 2 + 2*D`, taken modulo 2^ADDR_W. Here D is the 9-bit two's-complement value {`instrWord[12]`, `instrWord[7:0]`}. This holds whether the branch is taken or not.
- R9: After a sample that is not a branch (R2), `brTaken` and `linkWe` are 0, and `brTarget` and `linkData` keep their previous values.
- R10: The displacement extremes reach exactly +255 and -256 characters from the next instruction, including when the sum wraps around the top of the address space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction word and PC are valid this cycle |
| instrWord | input | 16 | Instruction word to resolve |
| flagN | input | 1 | Negative flag |
| flagV | input | 1 | Signed overflow flag |
| flagC | input | 1 | Carry / borrow flag |
| flagZ | input | 1 | Zero flag |
| curPc | input | ADDR_W | Byte address of the instruction word |
| isBranch | output | 1 | Previous sample was a branch word |
| brTaken | output | 1 | Previous branch is taken |
| brTarget | output | ADDR_W | Destination byte address of the last branch |
| linkWe | output | 1 | Write request for the link register |
| linkIdx | output | 4 | Register index to write (15 when requested) |
| linkData | output | ADDR_W | Return address for the link write |

## Verification
A wrong condition-table entry appears on `brTaken` in the cycle after the word is sampled. It shows up only for flag combinations that tell that code apart from its neighbours, so every code is driven with several flag patterns. An error in the displacement sign or scaling shows up on `brTarget` in that same cycle. Large forward and backward offsets, and offsets that wrap around the address space, expose it most quickly. A capture register that updates when it should hold is seen on the first non-branch sample that follows a branch.

// File: rtl/brres_pkg.sv
package brres_pkg;

  localparam logic [2:0] BR_MAJOR  = 3'b101;
  localparam logic [3:0] COND_CALL = 4'hF;
  localparam logic [3:0] LINK_REG  = 4'd15;

  typedef struct packed {
    logic capture;
    logic taken;
    logic link;
  } brStrobes_t;

  function automatic logic condHolds(input logic [3:0] code,
                                     input logic n, input logic v,
                                     input logic c, input logic z);
    logic lt;
    lt = n ^ v;
    case (code)
      4'h0: condHolds = lt;
      4'h1: condHolds = !lt;
      4'h2: condHolds = lt | z;
      4'h3: condHolds = !(lt | z);
      4'h4: condHolds = c;
      4'h5: condHolds = !c;
      4'h6: condHolds = c | z;
      4'h7: condHolds = !(c | z);
      4'h8: condHolds = z;
      4'h9: condHolds = !z;
      4'hA: condHolds = n;
      4'hB: condHolds = !n;
      4'hE: condHolds = 1'b1;
      4'hF: condHolds = 1'b1;
      default: condHolds = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/brres_ctrl.sv
module brres_ctrl
  import brres_pkg::*;
(
  input  logic        inValid,
  input  logic [15:0] instrWord,
  input  logic        flagN,
  input  logic        flagV,
  input  logic        flagC,
  input  logic        flagZ,
  output brStrobes_t  strobes
);

  localparam int NUM_COND = 16;

  logic [NUM_COND-1:0] condVec;
  logic [3:0]          condCode;
  logic                isBrWord;

  assign condCode = instrWord[11:8];
  assign isBrWord = inValid && (instrWord[15:13] == BR_MAJOR);

  for (genvar gi = 0; gi < NUM_COND; gi++) begin : g_cond
    assign condVec[gi] = condHolds(4'(gi), flagN, flagV, flagC, flagZ);
  end

  always_comb begin
    strobes.capture = isBrWord;
    strobes.taken   = isBrWord && condVec[condCode];
    strobes.link    = isBrWord && (condCode == COND_CALL);
  end

endmodule

// File: rtl/brres_dp.sv
module brres_dp
  import brres_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  brStrobes_t        strobes,
  input  logic [8:0]        dispField,
  input  logic [ADDR_W-1:0] curPc,
  output logic              isBranch,
  output logic              brTaken,
  output logic [ADDR_W-1:0] brTarget,
  output logic              linkWe,
  output logic [ADDR_W-1:0] linkData
);

  localparam int          EXT_W     = ADDR_W - 10;
  localparam int unsigned CHAR_BYTES = 2;

  logic [ADDR_W-1:0] seqPc;
  logic [ADDR_W-1:0] byteOffset;
  logic [ADDR_W-1:0] targetNext;

  assign seqPc      = curPc + ADDR_W'(CHAR_BYTES);
  assign byteOffset = {{EXT_W{dispField[8]}}, dispField, 1'b0};
  assign targetNext = seqPc + byteOffset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isBranch <= 1'b0;
      brTaken  <= 1'b0;
      linkWe   <= 1'b0;
      brTarget <= '0;
      linkData <= '0;
    end else begin
      isBranch <= strobes.capture;
      brTaken  <= strobes.taken;
      linkWe   <= strobes.link;
      if (strobes.capture) brTarget <= targetNext;
      if (strobes.link)    linkData <= seqPc;
    end
  end

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import brres_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [15:0]       instrWord,
  input  logic              flagN,
  input  logic              flagV,
  input  logic              flagC,
  input  logic              flagZ,
  input  logic [ADDR_W-1:0] curPc,
  output logic              isBranch,
  output logic              brTaken,
  output logic [ADDR_W-1:0] brTarget,
  output logic              linkWe,
  output logic [3:0]        linkIdx,
  output logic [ADDR_W-1:0] linkData
);

  brStrobes_t strobes;
  logic [8:0] dispField;

  assign dispField = {instrWord[12], instrWord[7:0]};

  brres_ctrl u_ctrl (
    .inValid  (inValid),
    .instrWord(instrWord),
    .flagN    (flagN),
    .flagV    (flagV),
    .flagC    (flagC),
    .flagZ    (flagZ),
    .strobes  (strobes)
  );

  brres_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .dispField(dispField),
    .curPc    (curPc),
    .isBranch (isBranch),
    .brTaken  (brTaken),
    .brTarget (brTarget),
    .linkWe   (linkWe),
    .linkData (linkData)
  );

  assign linkIdx = linkWe ? LINK_REG : 4'd0;

endmodule

// File: rtl/brres_chk.sv
module brres_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [15:0]       instrWord,
  input logic [ADDR_W-1:0] curPc,
  input logic              isBranch,
  input logic              brTaken,
  input logic [ADDR_W-1:0] brTarget,
  input logic              linkWe,
  input logic [3:0]        linkIdx,
  input logic [ADDR_W-1:0] linkData
);

  logic brIn;
  assign brIn = inValid && (instrWord[15:13] == 3'b101);

  // R2
  branch_seen_chk: assert property (@(posedge clk) disable iff (!rstN)
    brIn |=> isBranch);

  // R9
  nonbranch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !brIn |=> (!isBranch && !brTaken && !linkWe && $stable(brTarget) && $stable(linkData)));

  // R6
  reserved_never_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brIn && (instrWord[11:9] == 3'b110)) |=> !brTaken);

  // R7
  link_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> (brTaken && isBranch && linkIdx == 4'd15));

  // R7
  link_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brIn && instrWord[11:8] == 4'hF) |=> (linkData == $past(curPc) + ADDR_W'(2)));

  // R9
  taken_implies_branch_chk: assert property (@(posedge clk) disable iff (!rstN)
    brTaken |-> isBranch);

endmodule

bind branch_resolver brres_chk #(.ADDR_W(ADDR_W)) u_brres_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .instrWord(instrWord),
  .curPc    (curPc),
  .isBranch (isBranch),
  .brTaken  (brTaken),
  .brTarget (brTarget),
  .linkWe   (linkWe),
  .linkIdx  (linkIdx),
  .linkData (linkData)
);

// File: tb/branch_resolver_bench.sv
`timescale 1ns/1ps
module branch_resolver_bench;

  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rstN;
  logic              inValid;
  logic [15:0]       instrWord;
  logic              flagN, flagV, flagC, flagZ;
  logic [ADDR_W-1:0] curPc;
  logic              isBranch, brTaken, linkWe;
  logic [3:0]        linkIdx;
  logic [ADDR_W-1:0] brTarget, linkData;

  int compared = 0;
  int mismatched = 0;
  logic [ADDR_W-1:0] expTarget = '0;
  logic [ADDR_W-1:0] expLink = '0;

  always #4 clk = ~clk;

  branch_resolver #(.ADDR_W(ADDR_W)) u_branch_resolver (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .flagN(flagN), .flagV(flagV), .flagC(flagC), .flagZ(flagZ),
    .curPc(curPc), .isBranch(isBranch), .brTaken(brTaken),
    .brTarget(brTarget), .linkWe(linkWe), .linkIdx(linkIdx),
    .linkData(linkData)
  );

  function automatic bit modelCond(input int code, input bit n, input bit v,
                                   input bit c, input bit z);
    case (code)
      0: return n != v;
      1: return n == v;
      2: return (n != v) || z;
      3: return !((n != v) || z);
      4: return c;
      5: return !c;
      6: return c || z;
      7: return !(c || z);
      8: return z;
      9: return !z;
      10: return n;
      11: return !n;
      14, 15: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string condReq(input int code);
    if (code < 4) return "R3";
    if (code < 8) return "R4";
    if (code < 12) return "R5";
    if (code < 15) return "R6";
    return "R7";
  endfunction

  function automatic logic [15:0] mkBranch(input logic [3:0] code, input logic [8:0] disp);
    return {3'b101, disp[8], code, disp[7:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] modelTarget(input logic [ADDR_W-1:0] pc,
                                                    input logic [8:0] disp);
    int signed d;
    d = $signed(disp);
    return pc + ADDR_W'(2) + ADDR_W'(2 * d);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, compare at the next negedge
  task automatic step(input bit vld, input logic [15:0] word,
                      input bit n, input bit v, input bit c, input bit z,
                      input logic [ADDR_W-1:0] pc, input string tgtReq);
    bit isBr;
    int code;
    inValid = vld; instrWord = word; curPc = pc;
    flagN = n; flagV = v; flagC = c; flagZ = z;
    @(posedge clk);
    @(negedge clk);
    isBr = vld && (word[15:13] == 3'b101);
    code = int'(word[11:8]);
    if (isBr) begin
      expTarget = modelTarget(pc, {word[12], word[7:0]});
      if (code == 15) expLink = pc + ADDR_W'(2);
    end
    check("R2", 64'(isBranch), 64'(isBr));
    if (isBr) begin
      check(condReq(code), 64'(brTaken), 64'(modelCond(code, n, v, c, z)));
      check("R7", 64'(linkWe), 64'(code == 15));
      check("R7", 64'(linkIdx), (code == 15) ? 64'd15 : 64'd0);
      check(tgtReq, 64'(brTarget), 64'(expTarget));
      if (code == 15) check("R7", 64'(linkData), 64'(expLink));
    end else begin
      check("R9", 64'(brTaken), 64'd0);
      check("R9", 64'(linkWe), 64'd0);
      check("R9", 64'(brTarget), 64'(expTarget));
      check("R9", 64'(linkData), 64'(expLink));
    end
  endtask

  initial begin
    #1_600_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0; inValid = 1'b0; instrWord = '0; curPc = '0;
    flagN = 0; flagV = 0; flagC = 0; flagZ = 0;
    @(negedge clk);
    // R1: reset state while held and after one clock
    inValid = 1'b1; instrWord = mkBranch(4'hF, 9'h055); curPc = 32'h1000;
    @(posedge clk); @(negedge clk);
    check("R1", 64'(isBranch), 0);
    check("R1", 64'(brTaken), 0);
    check("R1", 64'(linkWe), 0);
    check("R1", 64'(linkIdx), 0);
    check("R1", 64'(brTarget), 0);
    check("R1", 64'(linkData), 0);
    rstN = 1'b1;

    // every condition code under all sixteen flag patterns (R3, R4, R5, R6, R7)
    for (int code = 0; code < 16; code++) begin
      for (int f = 0; f < 16; f++) begin
        step(1'b1, mkBranch(4'(code), 9'(code * 7 + f)), f[3], f[2], f[1], f[0],
             32'h0000_4000 + 32'(code * 64 + f * 2), "R8");
      end
    end

    // R10: displacement extremes and wrap
    step(1'b1, mkBranch(4'hE, 9'h0FF), 0, 0, 0, 0, 32'h0000_2000, "R10");
    check("R10", 64'(brTarget), 64'h0000_2200);
    step(1'b1, mkBranch(4'hE, 9'h100), 0, 0, 0, 0, 32'h0000_2000, "R10");
    check("R10", 64'(brTarget), 64'h0000_1E02);
    step(1'b1, mkBranch(4'hF, 9'h0FF), 0, 0, 0, 0, 32'hFFFF_FFFE, "R10");
    check("R10", 64'(brTarget), 64'h0000_01FE);
    check("R7", 64'(linkData), 64'h0);
    step(1'b1, mkBranch(4'h8, 9'h100), 0, 0, 0, 1, 32'h0000_0010, "R10");
    check("R10", 64'(brTarget), 64'hFFFF_FE12);

    // R9: non-branch words and invalid branch words hold state
    step(1'b1, 16'h8F12, 1, 1, 1, 1, 32'h0000_9000, "R9");
    step(1'b0, mkBranch(4'hF, 9'h011), 0, 0, 0, 0, 32'h0000_9100, "R9");
    step(1'b1, 16'hE0FF, 0, 0, 0, 0, 32'h0000_9200, "R9");
    step(1'b1, 16'h4FFF, 0, 0, 0, 0, 32'h0000_9300, "R9");

    // constrained random mix (R2..R9)
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      logic [3:0]  fl;
      w  = 16'($urandom);
      if ($urandom_range(1, 0) == 1) w[15:13] = 3'b101;
      fl = 4'($urandom);
      step(($urandom_range(9, 0) != 0), w, fl[3], fl[2], fl[1], fl[0],
           {32'($urandom)} & 32'hFFFF_FFFE, "R8");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule